// File: doc/BRIEF.md
# Fixed-Frequency PWM Gate Controller

This block is the digital decision path of a fixed-frequency pulse-width modulator for a switching power stage. A free-running counter acts as the oscillator. Its value is exported as a ramp for external slope compensation. A short clock pulse is active over the first counts after each wrap to zero. The falling edge of that pulse starts an on-time. A comparator-trip input that is already synchronous to the clock ends the on-time early. The trip does not act on the gate directly; it sets an off-latch that only the next oscillator pulse clears.

The trip input is masked for a fixed blanking window at the start of each on-time, so that turn-on spikes cannot end the pulse. Three fault inputs can force the gate low: an active-low over-temperature flag, an external shutdown and an undervoltage lockout. Each passes through a two-stage synchronizer. A fault latches a hold that is released only during an oscillator pulse, so switching never restarts in the middle of a period. The gate enable is registered.

The oscillator period, the pulse width and the blanking length are parameters counted in clock cycles. The blanking window must end before the period does: PULSE_CYC + BLANK_CYC + 1 < PERIOD.

Top module: `pwm_gate_ctrl`

## Requirements
- R1: `ramp_o` counts up by one each clock from 0 to PERIOD-1, wraps to 0, and reads 0 after reset.
- R2: `osc_pulse_o` is high exactly while `ramp_o` < PULSE_CYC. `gate_en_o` is low in the cycle that follows any cycle with the pulse high.
- R3: With no trip and no fault, `gate_en_o` goes high when `ramp_o` reads PULSE_CYC+1. It stays high through the wrap and up to the cycle in which `ramp_o` reads 0.
- R4: A trip sampled high on the edge that leaves `ramp_o` at value c (c outside both the pulse and the blanking window) drives `gate_en_o` low when `ramp_o` reads c+2. It stays low until the next period's on-time.
- R5: A trip sampled while `ramp_o` is in [PULSE_CYC, PULSE_CYC+BLANK_CYC) has no effect, and the gate stays high for the rest of the period.
- R6: The off-latch is set-dominant. A trip sampled during the last pulse count (`ramp_o` = PULSE_CYC-1) coincides with the clearing pulse, the latch stays set, and `gate_en_o` stays low for that entire period.
- R7: `ot_n_i` low, `shdn_i` high or `uvlo_i` high drives `gate_en_o` low within four clock edges of the input change, and keeps it low while the fault lasts.
- R8: After a fault clears, `gate_en_o` stays low for the rest of the period. It returns high only at `ramp_o` = PULSE_CYC+1 of a later period.
- R9: During and right after synchronous reset, `gate_en_o` is 0 and `ramp_o` is 0.
- R10: The gate is high for at most PERIOD-PULSE_CYC cycles in any period.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| trip_i | input | 1 | Comparator trip, synchronous to clk, high = end on-time |
| ot_n_i | input | 1 | Over-temperature flag, active low |
| shdn_i | input | 1 | External shutdown, active high |
| uvlo_i | input | 1 | Undervoltage lockout, active high |
| gate_en_o | output | 1 | Registered gate-drive enable |
| osc_pulse_o | output | 1 | Oscillator clock pulse |
| ramp_o | output | $clog2(PERIOD) | Oscillator ramp count |

## Verification
The assertions assume that `trip_i` is already synchronous to `clk`, and that the parameters keep the blanking window inside the period. Fault inputs are taken to be asynchronous and to persist for at least two clocks. The random stimulus changes `trip_i` and the fault levels only at the falling clock edge. It holds each fault level for many cycles. Directed cases place trips at the last pulse count, inside the blanking window and mid-period, and apply each fault alone at a known ramp value.

// File: rtl/pwm_gate_pkg.sv
package pwm_gate_pkg;
  localparam int NUM_FLT = 3;
  typedef enum int {
    FLT_OVERTEMP = 0,
    FLT_SHUTDOWN = 1,
    FLT_UNDERVOLT = 2
  } flt_idx_e;
endpackage

// File: rtl/pwm_ramp_osc.sv
module pwm_ramp_osc #(
  parameter int PERIOD    = 1000,
  parameter int PULSE_CYC = 10
) (
  input  logic                        clk,
  input  logic                        rst,
  output logic [$clog2(PERIOD)-1:0]   ramp_o,
  output logic                        pulse_o
);
  localparam int CW = $clog2(PERIOD);
  localparam logic [CW-1:0] LAST = CW'(PERIOD - 1);
  localparam logic [CW-1:0] PW   = CW'(PULSE_CYC);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst)                cnt_q <= '0;
    else if (cnt_q == LAST) cnt_q <= '0;
    else                    cnt_q <= cnt_q + 1'b1;
  end

  assign ramp_o  = cnt_q;
  assign pulse_o = (cnt_q < PW);

  // R1: wrap to zero after the last count
  p_wrap_r1: assert property (@(posedge clk) disable iff (rst)
    (cnt_q == LAST) |=> (cnt_q == '0));
  // R1: single step otherwise
  p_step_r1: assert property (@(posedge clk) disable iff (rst)
    (cnt_q != LAST) |=> (cnt_q == $past(cnt_q) + 1'b1));
endmodule

// File: rtl/pwm_fault_sync.sv
module pwm_fault_sync #(
  parameter int N = 3
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [N-1:0] flt_i,
  output logic         any_o
);
  logic [N-1:0] s1_q, s2_q;

  for (genvar i = 0; i < N; i++) begin : g_sync
    always_ff @(posedge clk) begin
      if (rst) begin
        s1_q[i] <= 1'b1;
        s2_q[i] <= 1'b1;
      end else begin
        s1_q[i] <= flt_i[i];
        s2_q[i] <= s1_q[i];
      end
    end
  end

  assign any_o = |s2_q;

  // R7: a fault seen two edges ago reaches the combined output
  p_sync_r7: assert property (@(posedge clk) disable iff (rst)
    (|$past(flt_i, 2)) |-> any_o);
endmodule

// File: rtl/pwm_off_latch.sv
module pwm_off_latch #(
  parameter int PERIOD    = 1000,
  parameter int PULSE_CYC = 10,
  parameter int BLANK_CYC = 20
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic [$clog2(PERIOD)-1:0]   ramp_i,
  input  logic                        pulse_i,
  input  logic                        trip_i,
  output logic                        off_o
);
  localparam int CW = $clog2(PERIOD);
  localparam logic [CW-1:0] BLK_LO = CW'(PULSE_CYC);
  localparam logic [CW-1:0] BLK_HI = CW'(PULSE_CYC + BLANK_CYC);

  logic blank, set_w, off_q;

  assign blank = (ramp_i >= BLK_LO) && (ramp_i < BLK_HI);
  assign set_w = trip_i && !blank;

  always_ff @(posedge clk) begin
    if (rst)          off_q <= 1'b0;
    else if (set_w)   off_q <= 1'b1;
    else if (pulse_i) off_q <= 1'b0;
  end

  assign off_o = off_q;

  // R6: set wins over reset
  p_setdom_r6: assert property (@(posedge clk) disable iff (rst)
    (trip_i && pulse_i) |=> off_q);
  // R5: latch cannot change inside the blanking window
  p_blank_r5: assert property (@(posedge clk) disable iff (rst)
    blank |=> (off_q == $past(off_q)));
endmodule

// File: rtl/pwm_gate_ctrl.sv
module pwm_gate_ctrl #(
  parameter int PERIOD    = 1000,
  parameter int PULSE_CYC = 10,
  parameter int BLANK_CYC = 20
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic                        trip_i,
  input  logic                        ot_n_i,
  input  logic                        shdn_i,
  input  logic                        uvlo_i,
  output logic                        gate_en_o,
  output logic                        osc_pulse_o,
  output logic [$clog2(PERIOD)-1:0]   ramp_o
);
  import pwm_gate_pkg::*;
  localparam int CW = $clog2(PERIOD);
  localparam logic [CW-1:0] ON_START = CW'(PULSE_CYC + 1);

  logic [CW-1:0]      ramp;
  logic               pulse, off, fault_s, hold_q, gate_q;
  logic [NUM_FLT-1:0] flt_raw;

  pwm_ramp_osc #(.PERIOD(PERIOD), .PULSE_CYC(PULSE_CYC)) u_osc (
    .clk(clk), .rst(rst), .ramp_o(ramp), .pulse_o(pulse));

  assign flt_raw[FLT_OVERTEMP]  = ~ot_n_i;
  assign flt_raw[FLT_SHUTDOWN]  = shdn_i;
  assign flt_raw[FLT_UNDERVOLT] = uvlo_i;

  pwm_fault_sync #(.N(NUM_FLT)) u_sync (
    .clk(clk), .rst(rst), .flt_i(flt_raw), .any_o(fault_s));

  pwm_off_latch #(.PERIOD(PERIOD), .PULSE_CYC(PULSE_CYC), .BLANK_CYC(BLANK_CYC)) u_latch (
    .clk(clk), .rst(rst), .ramp_i(ramp), .pulse_i(pulse), .trip_i(trip_i), .off_o(off));

  // fault hold: released only while the oscillator pulse is active
  always_ff @(posedge clk) begin
    if (rst)          hold_q <= 1'b1;
    else if (fault_s) hold_q <= 1'b1;
    else if (pulse)   hold_q <= 1'b0;
  end

  always_ff @(posedge clk) begin
    if (rst) gate_q <= 1'b0;
    else     gate_q <= ~(off | pulse | hold_q);
  end

  assign gate_en_o   = gate_q;
  assign osc_pulse_o = pulse;
  assign ramp_o      = ramp;

  // R2: pulse forces the gate low on the following cycle
  p_pulse_low_r2: assert property (@(posedge clk) disable iff (rst)
    pulse |=> !gate_q);
  // R7: an active fault hold keeps the gate low
  p_fault_low_r7: assert property (@(posedge clk) disable iff (rst)
    hold_q |=> !gate_q);
  // R8: turn-on happens only at the fixed on-time start
  p_turn_on_r8: assert property (@(posedge clk) disable iff (rst)
    $rose(gate_q) |-> (ramp == ON_START));
  // R4: a set latch turns the gate off on the next cycle
  p_off_low_r4: assert property (@(posedge clk) disable iff (rst)
    off |=> !gate_q);
endmodule

// File: tb/sim_pwm_gate_ctrl.sv
`timescale 1ns/1ps
module sim_pwm_gate_ctrl;
  localparam int P  = 40;
  localparam int W  = 4;
  localparam int B  = 6;
  localparam int CW = $clog2(P);

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic trip = 1'b0, ot_n = 1'b1, shdn = 1'b0, uvlo = 1'b0;
  logic gate;
  logic pulse;
  logic [CW-1:0] ramp;

  int vectors = 0;
  int fails = 0;
  bit done = 1'b0;
  string tag = "R9";

  // model state
  int m_cnt;
  bit [2:0] m_s1, m_s2;
  bit m_hold, m_off, m_gate;

  always #5 clk = ~clk;

  pwm_gate_ctrl #(.PERIOD(P), .PULSE_CYC(W), .BLANK_CYC(B)) u0 (
    .clk(clk), .rst(rst), .trip_i(trip), .ot_n_i(ot_n), .shdn_i(shdn),
    .uvlo_i(uvlo), .gate_en_o(gate), .osc_pulse_o(pulse), .ramp_o(ramp));

  task automatic chk(string t, int act, int exp);
    vectors++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d (ramp %0d)", t, act, exp, ramp);
    end
  endtask

  task automatic model_reset();
    m_cnt = 0; m_s1 = 3'b111; m_s2 = 3'b111;
    m_hold = 1'b1; m_off = 1'b0; m_gate = 1'b0;
  endtask

  function automatic bit exp_pulse(int c);
    return c < W;
  endfunction

  task automatic model_step();
    bit pl, blk, flt, n_hold, n_off, n_gate;
    pl  = exp_pulse(m_cnt);
    blk = (m_cnt >= W) && (m_cnt < W + B);
    flt = |m_s2;
    n_gate = !(m_off || pl || m_hold);
    n_hold = flt ? 1'b1 : (pl ? 1'b0 : m_hold);
    n_off  = (trip && !blk) ? 1'b1 : (pl ? 1'b0 : m_off);
    m_s2 = m_s1;
    m_s1 = {uvlo, shdn, ~ot_n};
    m_cnt = (m_cnt == P - 1) ? 0 : m_cnt + 1;
    m_hold = n_hold; m_off = n_off; m_gate = n_gate;
  endtask

  // one clock: model advances with the inputs now applied, compare at negedge
  task automatic cyc();
    model_step();
    @(negedge clk);
    chk({tag, " ramp R1"}, int'(ramp), m_cnt);
    chk({tag, " pulse R2"}, int'(pulse), int'(exp_pulse(m_cnt)));
    chk({tag, " gate"}, int'(gate), int'(m_gate));
  endtask

  task automatic wait_ramp(int v);
    for (int i = 0; i < 2 * P && int'(ramp) != v; i++) cyc();
  endtask

  initial begin
    int hi;
    void'($urandom(32'd20240611));
    model_reset();
    repeat (3) @(negedge clk);
    chk("R9 reset gate", int'(gate), 0);
    chk("R9 reset ramp", int'(ramp), 0);
    rst = 1'b0;

    tag = "R3";
    repeat (2 * P) cyc();
    wait_ramp(W);
    cyc();
    chk("R3 turn-on at PULSE+1", int'(gate), 1);
    // R10: count on cycles across a whole period
    hi = 0;
    for (int i = 0; i < P; i++) begin cyc(); hi += int'(gate); end
    chk("R10 on cycles per period", hi, P - W);

    tag = "R4";
    wait_ramp(19);
    trip = 1'b1; cyc(); trip = 1'b0;
    chk("R4 gate one cycle after trip", int'(gate), 1);
    cyc();
    chk("R4 gate off two cycles after trip", int'(gate), 0);
    wait_ramp(P - 1);
    chk("R4 stays off to period end", int'(gate), 0);

    tag = "R5";
    wait_ramp(W - 1);
    cyc();
    trip = 1'b1;
    repeat (B) cyc();
    trip = 1'b0;
    wait_ramp(25);
    chk("R5 blanked trip ignored", int'(gate), 1);

    tag = "R6";
    wait_ramp(W - 1);
    trip = 1'b1; cyc(); trip = 1'b0;
    wait_ramp(W + 1);
    chk("R6 set-dominant, no turn-on", int'(gate), 0);
    wait_ramp(P - 1);
    chk("R6 off whole period", int'(gate), 0);

    for (int f = 0; f < 3; f++) begin
      tag = "R7";
      wait_ramp(15);
      if (f == 0) ot_n = 1'b0; else if (f == 1) shdn = 1'b1; else uvlo = 1'b1;
      repeat (4) cyc();
      chk("R7 fault forces gate low", int'(gate), 0);
      ot_n = 1'b1; shdn = 1'b0; uvlo = 1'b0;
      tag = "R8";
      wait_ramp(P - 1);
      chk("R8 no mid-period resume", int'(gate), 0);
      wait_ramp(W + 1);
      chk("R8 resume at next on-time", int'(gate), 1);
    end

    tag = "R4/R7 random";
    for (int i = 0; i < 4000; i++) begin
      trip = ($urandom % 12) == 0;
      if ($urandom % 150 == 0) ot_n = ~ot_n;
      if ($urandom % 200 == 0) shdn = ~shdn;
      if ($urandom % 250 == 0) uvlo = ~uvlo;
      cyc();
    end
    trip = 1'b0; ot_n = 1'b1; shdn = 1'b0; uvlo = 1'b0;
    tag = "R8 recovery";
    repeat (3 * P) cyc();

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

  initial begin
    #1_000_000;
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual hung expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  end
endmodule